// File: doc/BRIEF.md
# Memory DLL Start-Up Sequencer

This controller-side block takes an external synchronous SRAM's delay-locked loop from power-up to a locked state, and only then lets normal traffic start. It waits until both power and the controller clock are reported good. It then resets the memory DLL in one of two ways. The first drives the active-low DLL-off line low and then high again. The second holds that line high and stops the memory clock pair for a minimum time. After the reset it counts a fixed number of lock cycles before it raises `ready`. If the DLL is to stay bypassed, it keeps DLL-off low and waits only a short initialization count. It reports whether the read datapath must use one-cycle latency (bypass) or one-and-a-half-cycle latency (DLL running).

A frequency-change request drops `ready` and runs the whole reset-and-lock sequence again, using the method and mode currently selected. Bypass is allowed only when the parameterized clock frequency is at most `BYPASS_MAX_MHZ`. The clock-stop time is a cycle count, computed from a nanosecond minimum and the clock period and rounded up. All counting uses the one clock `clk`.

Top module: `dll_init_seq`

## Requirements
- R1: While `powerGood` or `clockStable` is low, and from reset, the block holds `dllOffN`=0, `memClkEn`=0 and `ready`=0, and no sequence starts.
- R2: With DLL mode and `stopMethodSel`=0, a sequence first holds `dllOffN`=0 with `memClkEn`=1 for exactly `PULSE_CYCLES` cycles, and then drives `dllOffN` high.
- R3: With DLL mode and `stopMethodSel`=1, a sequence holds `memClkEn`=0 with `dllOffN`=1 for exactly ceil(`STOP_MIN_PS`/`CLK_PERIOD_PS`) cycles (6 at 5000 ps, 5 at 6000 ps).
- R4: In DLL mode, `ready` rises exactly `LOCK_CYCLES` (default 2048) cycles after the memory clock is running with `dllOffN` high, so it is never sooner than `LOCK_CYCLES` cycles after `dllOffN` rises.
- R5: In bypass mode, `dllOffN` stays 0, the clock runs, and `ready` rises after exactly `INIT_CYCLES` cycles. The clock-stop method is not used. `latencyMode` reads 0 (one-cycle latency).
- R6: If 1,000,000/`CLK_PERIOD_PS` MHz exceeds `BYPASS_MAX_MHZ`, a bypass request is ignored and the block runs DLL mode. When `ready` is high in DLL mode, `dllOffN`=1, `memClkEn`=1 and `latencyMode`=1 (1.5-cycle latency).
- R7: A `freqChangeReq` sampled high drops `ready` in the next cycle and restarts the selected reset method and the full count.
- R8: Dropping `powerGood` or `clockStable` at any time returns all outputs to the R1 idle values in the next cycle. A later return of both starts a fresh sequence.
- R9: `bypassReq` and `stopMethodSel` are sampled only when a sequence starts. Changes while `ready` is high have no effect on `dllOffN`, `memClkEn`, `ready` or `latencyMode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; every count is in its cycles |
| rstN | input | 1 | Asynchronous active-low reset |
| powerGood | input | 1 | Supplies are stable |
| clockStable | input | 1 | Controller clock is stable |
| freqChangeReq | input | 1 | Request to re-run reset and lock after a frequency change |
| bypassReq | input | 1 | Ask to keep the DLL bypassed |
| stopMethodSel | input | 1 | 1 = reset by clock stop, 0 = reset by DLL-off pulse |
| dllOffN | output | 1 | Active-low DLL-off control to the memory |
| memClkEn | output | 1 | Enable for the memory clock pair |
| ready | output | 1 | Memory may carry traffic |
| latencyMode | output | 1 | 0 = one-cycle read latency, 1 = 1.5-cycle read latency |

## Verification
A corrupted phase counter or terminal compare shows up at the ports as a wrong number of cycles in one output phase: the DLL-off low pulse, the clock-gated window, or the gap between DLL-off rising and `ready`. So the bench measures every phase length to the exact cycle on each sequence. A state register that keeps a stale mode appears within one cycle as a mismatch between `dllOffN` and `latencyMode` while `ready` is high. A missed restart appears as `ready` still high in the cycle after a frequency-change request or a supply drop. Two instances with different clock-period parameters cover both the stop-time rounding and the bypass frequency limit.

// File: rtl/dll_init_pkg.sv
package dll_init_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PULSE,
    S_STOP,
    S_LOCK,
    S_INIT,
    S_READY
  } seqState_t;

  // index of each counted phase in the terminal-flag vector
  localparam int PH_PULSE = 0;
  localparam int PH_STOP  = 1;
  localparam int PH_LOCK  = 2;
  localparam int PH_INIT  = 3;
  localparam int PH_COUNT = 4;

  localparam logic LAT_ONE      = 1'b0;
  localparam logic LAT_ONE_HALF = 1'b1;

  typedef struct packed {
    logic clear;
    logic run;
  } cntCtrl_t;

endpackage

// File: rtl/dll_init_count.sv
module dll_init_count
  import dll_init_pkg::*;
#(
  parameter int PULSE_CYCLES = 4,
  parameter int STOP_CYCLES  = 6,
  parameter int LOCK_CYCLES  = 2048,
  parameter int INIT_CYCLES  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  cntCtrl_t            ctl,
  output logic [PH_COUNT-1:0] phaseDone
);

  localparam int MAX_A   = (PULSE_CYCLES > STOP_CYCLES) ? PULSE_CYCLES : STOP_CYCLES;
  localparam int MAX_B   = (LOCK_CYCLES > INIT_CYCLES) ? LOCK_CYCLES : INIT_CYCLES;
  localparam int MAX_LIM = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_LIM + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cnt <= '0;
    else if (ctl.clear) cnt <= '0;
    else if (ctl.run)   cnt <= cnt + 1'b1;
  end

  for (genvar i = 0; i < PH_COUNT; i++) begin : g_done
    localparam int LIM = (i == PH_PULSE) ? PULSE_CYCLES :
                         (i == PH_STOP)  ? STOP_CYCLES  :
                         (i == PH_LOCK)  ? LOCK_CYCLES  : INIT_CYCLES;
    assign phaseDone[i] = (cnt == CNT_W'(LIM - 1));
  end

  // R4: the phase counter never runs past the longest phase
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rstN)
    cnt < CNT_W'(MAX_LIM));

endmodule

// File: rtl/dll_init_ctrl.sv
module dll_init_ctrl
  import dll_init_pkg::*;
#(
  parameter int   LOCK_CYCLES = 2048,
  parameter logic BYPASS_OK   = 1'b0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                powerGood,
  input  logic                clockStable,
  input  logic                freqChangeReq,
  input  logic                bypassReq,
  input  logic                stopMethodSel,
  input  logic [PH_COUNT-1:0] phaseDone,
  output cntCtrl_t            ctl,
  output logic                dllOffN,
  output logic                memClkEn,
  output logic                ready,
  output logic                latencyMode
);

  seqState_t state, stateNext, startState;
  logic supplyOk, restart, bypassUse, bypassLat;

  always_comb begin
    supplyOk   = powerGood && clockStable;
    restart    = supplyOk && ((state == S_IDLE) || freqChangeReq);
    bypassUse  = bypassReq && BYPASS_OK;
    startState = bypassUse ? S_INIT : (stopMethodSel ? S_STOP : S_PULSE);
    stateNext  = state;
    if (!supplyOk)    stateNext = S_IDLE;
    else if (restart) stateNext = startState;
    else begin
      case (state)
        S_PULSE: if (phaseDone[PH_PULSE]) stateNext = S_LOCK;
        S_STOP:  if (phaseDone[PH_STOP])  stateNext = S_LOCK;
        S_LOCK:  if (phaseDone[PH_LOCK])  stateNext = S_READY;
        S_INIT:  if (phaseDone[PH_INIT])  stateNext = S_READY;
        default: stateNext = state;
      endcase
    end
    ctl.clear = restart || (stateNext != state);
    ctl.run   = (state != S_IDLE) && (state != S_READY);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      bypassLat <= 1'b0;
    end else begin
      state <= stateNext;
      if (restart) bypassLat <= bypassUse;
    end
  end

  always_comb begin
    dllOffN     = (state == S_STOP) || (state == S_LOCK) ||
                  ((state == S_READY) && !bypassLat);
    memClkEn    = (state == S_PULSE) || (state == S_LOCK) ||
                  (state == S_INIT) || (state == S_READY);
    ready       = (state == S_READY);
    latencyMode = bypassLat ? LAT_ONE : LAT_ONE_HALF;
  end

  // cycles since DLL-off last rose, saturating; used by R4 check only
  localparam int SR_W = $clog2(LOCK_CYCLES + 1);
  logic [SR_W-1:0] sinceRise;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              sinceRise <= '0;
    else if (!dllOffN)                      sinceRise <= '0;
    else if (sinceRise < SR_W'(LOCK_CYCLES)) sinceRise <= sinceRise + 1'b1;
  end

  p_idle_outputs_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(powerGood && clockStable) |=> (!ready && !memClkEn && !dllOffN));

  p_lock_wait_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(ready) && dllOffN) |-> (sinceRise >= SR_W'(LOCK_CYCLES)));

  p_bypass_dll_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !dllOffN) |-> (latencyMode == LAT_ONE));

  p_freq_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
    freqChangeReq |=> !ready);

  p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ready && $past(ready)) |-> ($stable(latencyMode) && $stable(dllOffN)));

  if (!BYPASS_OK) begin : g_fast_clk
    p_no_bypass_r6: assert property (@(posedge clk) disable iff (!rstN)
      ready |-> (dllOffN && latencyMode == LAT_ONE_HALF));
  end

endmodule

// File: rtl/dll_init_seq.sv
module dll_init_seq
  import dll_init_pkg::*;
#(
  parameter int CLK_PERIOD_PS  = 5000,
  parameter int STOP_MIN_PS    = 30000,
  parameter int BYPASS_MAX_MHZ = 167,
  parameter int LOCK_CYCLES    = 2048,
  parameter int PULSE_CYCLES   = 4,
  parameter int INIT_CYCLES    = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic powerGood,
  input  logic clockStable,
  input  logic freqChangeReq,
  input  logic bypassReq,
  input  logic stopMethodSel,
  output logic dllOffN,
  output logic memClkEn,
  output logic ready,
  output logic latencyMode
);

  localparam int   STOP_CYCLES = (STOP_MIN_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam logic BYPASS_OK   = (CLK_PERIOD_PS * BYPASS_MAX_MHZ) >= 1000000;

  cntCtrl_t            ctl;
  logic [PH_COUNT-1:0] phaseDone;

  dll_init_ctrl #(
    .LOCK_CYCLES (LOCK_CYCLES),
    .BYPASS_OK   (BYPASS_OK)
  ) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .powerGood     (powerGood),
    .clockStable   (clockStable),
    .freqChangeReq (freqChangeReq),
    .bypassReq     (bypassReq),
    .stopMethodSel (stopMethodSel),
    .phaseDone     (phaseDone),
    .ctl           (ctl),
    .dllOffN       (dllOffN),
    .memClkEn      (memClkEn),
    .ready         (ready),
    .latencyMode   (latencyMode)
  );

  dll_init_count #(
    .PULSE_CYCLES (PULSE_CYCLES),
    .STOP_CYCLES  (STOP_CYCLES),
    .LOCK_CYCLES  (LOCK_CYCLES),
    .INIT_CYCLES  (INIT_CYCLES)
  ) u_count (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .phaseDone (phaseDone)
  );

endmodule

// File: tb/dll_init_seq_test.sv
`timescale 1ns/1ps
module dll_init_seq_test;

  localparam int LOCK  = 2048;
  localparam int PULSE = 4;
  localparam int INIT  = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic powerGood = 1'b0, clockStable = 1'b0, freqChangeReq = 1'b0;
  logic bypassReq = 1'b0, stopMethodSel = 1'b0;
  logic offA, clkEnA, rdyA, latA;
  logic offB, clkEnB, rdyB, latB;

  int checks = 0, errors = 0, cycles = 0;
  int stopExpA, stopExpB;
  bit bypassOkA, bypassOkB;

  always #2.5 clk = ~clk;

  // default period 5000 ps (200 MHz)
  dll_init_seq uut (
    .clk(clk), .rstN(rstN), .powerGood(powerGood), .clockStable(clockStable),
    .freqChangeReq(freqChangeReq), .bypassReq(bypassReq), .stopMethodSel(stopMethodSel),
    .dllOffN(offA), .memClkEn(clkEnA), .ready(rdyA), .latencyMode(latA));

  // slower parameterized clock (6000 ps) so bypass is permitted
  dll_init_seq #(.CLK_PERIOD_PS(6000)) uutSlow (
    .clk(clk), .rstN(rstN), .powerGood(powerGood), .clockStable(clockStable),
    .freqChangeReq(freqChangeReq), .bypassReq(bypassReq), .stopMethodSel(stopMethodSel),
    .dllOffN(offB), .memClkEn(clkEnB), .ready(rdyB), .latencyMode(latB));

  function automatic logic [3:0] getOut(input int sel);
    return (sel == 0) ? {offA, clkEnA, rdyA, latA} : {offB, clkEnB, rdyB, latB};
  endfunction

  task automatic checkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic runSeq(input int sel, input bit pulseFreq,
                        output int nPulse, output int nStop, output int nLock,
                        output int nIdle, output int firstRdy);
    logic [3:0] o;
    nPulse = 0; nStop = 0; nLock = 0; nIdle = 0; firstRdy = -1;
    if (pulseFreq) freqChangeReq = 1'b1;
    for (int k = 0; k < 6000; k++) begin
      @(negedge clk);
      freqChangeReq = 1'b0;
      o = getOut(sel);
      if (k == 0) firstRdy = int'(o[1]);
      if (o[1]) break;
      if (!o[3] && o[2])      nPulse++;
      else if (o[3] && !o[2]) nStop++;
      else if (o[3] && o[2])  nLock++;
      else                    nIdle++;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int np, ns, nl, ni, fr;
    stopExpA  = int'($ceil(30.0 / 5.0));
    stopExpB  = int'($ceil(30.0 / 6.0));
    bypassOkA = (1000.0 / 5.0) <= 167.0;
    bypassOkB = (1000.0 / 6.0) <= 167.0;

    // R1: reset state
    #1;
    checkEq("R1 reset dllOffN", offA, 0);
    checkEq("R1 reset memClkEn", clkEnA, 0);
    checkEq("R1 reset ready", rdyA, 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: power good without clock stable keeps idle
    powerGood = 1'b1;
    repeat (20) @(negedge clk);
    checkEq("R1 no clockStable outputs", {offA, clkEnA, rdyA}, 0);

    // R2/R4: pulse method from power-up
    clockStable = 1'b1;
    runSeq(0, 1'b0, np, ns, nl, ni, fr);
    checkEq("R2 pulse length", np, PULSE);
    checkEq("R2 no clock stop", ns, 0);
    checkEq("R4 lock wait after rise", nl, LOCK);
    checkEq("R6 dllOffN high at ready", offA, 1);
    checkEq("R6 latency 1.5 at ready", latA, 1);
    checkEq("R6 clock on at ready", clkEnA, 1);
    @(negedge clk);
    checkEq("R6 slow inst DLL latency", {rdyB, offB, latB}, 3'b111);

    // R9: mode inputs ignored while ready
    bypassReq = 1'b1; stopMethodSel = 1'b1;
    repeat (5) @(negedge clk);
    checkEq("R9 fast inst unchanged", {offA, clkEnA, rdyA, latA}, 4'b1111);
    checkEq("R9 slow inst unchanged", {offB, clkEnB, rdyB, latB}, 4'b1111);
    bypassReq = 1'b0;

    // R7/R3: frequency change, clock-stop method, 200 MHz period
    runSeq(0, 1'b1, np, ns, nl, ni, fr);
    checkEq("R7 ready dropped next cycle", fr, 0);
    checkEq("R3 stop length 5000ps", ns, stopExpA);
    checkEq("R3 no DLL-off pulse", np, 0);
    checkEq("R4 relock count stop", nl, LOCK);

    // R3: rounding at 6000 ps on the slow instance
    runSeq(1, 1'b1, np, ns, nl, ni, fr);
    checkEq("R3 stop length 6000ps", ns, stopExpB);
    checkEq("R4 relock count slow", nl, LOCK);

    // R7/R2: frequency change with pulse method
    stopMethodSel = 1'b0;
    runSeq(0, 1'b1, np, ns, nl, ni, fr);
    checkEq("R7 ready dropped pulse", fr, 0);
    checkEq("R2 pulse length rerun", np, PULSE);
    checkEq("R4 relock count pulse", nl, LOCK);

    // R8: clock-stable drops mid-lock
    freqChangeReq = 1'b1;
    @(negedge clk); freqChangeReq = 1'b0;
    repeat (100) @(negedge clk);
    clockStable = 1'b0;
    @(negedge clk);
    checkEq("R8 idle after clockStable drop", {offA, clkEnA, rdyA}, 0);
    checkEq("R8 slow idle", {offB, clkEnB, rdyB}, 0);
    clockStable = 1'b1;
    runSeq(0, 1'b0, np, ns, nl, ni, fr);
    checkEq("R8 fresh pulse", np, PULSE);
    checkEq("R8 fresh lock", nl, LOCK);

    // R5: bypass on the slow instance
    bypassReq = 1'b1;
    runSeq(1, 1'b1, np, ns, nl, ni, fr);
    checkEq("R5 bypass allowed at 6000ps", int'(bypassOkB), 1);
    checkEq("R5 init count", np, INIT);
    checkEq("R5 no lock phase", nl, 0);
    checkEq("R5 dllOffN low at ready", offB, 0);
    checkEq("R5 one-cycle latency", latB, 0);
    repeat (3000) @(negedge clk);

    // R6: bypass refused on the fast instance
    runSeq(0, 1'b1, np, ns, nl, ni, fr);
    checkEq("R6 bypass refused at 5000ps", int'(bypassOkA), 0);
    checkEq("R6 DLL pulse used", np, PULSE);
    checkEq("R6 lock phase used", nl, LOCK);
    checkEq("R6 outputs at ready", {offA, latA}, 2'b11);

    // R5: bypass overrides the clock-stop method
    stopMethodSel = 1'b1;
    runSeq(1, 1'b1, np, ns, nl, ni, fr);
    checkEq("R5 no clock stop in bypass", ns, 0);
    checkEq("R5 init count stop sel", np, INIT);
    repeat (3000) @(negedge clk);

    // R1/R3: power drop, then power-up with clock-stop method
    bypassReq = 1'b0;
    powerGood = 1'b0;
    @(negedge clk);
    checkEq("R1 idle on power loss", {offA, clkEnA, rdyA}, 0);
    repeat (10) @(negedge clk);
    powerGood = 1'b1;
    runSeq(0, 1'b0, np, ns, nl, ni, fr);
    checkEq("R3 power-up stop length", ns, stopExpA);
    checkEq("R4 power-up lock", nl, LOCK);
    checkEq("R1 no idle gap after start", ni, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule